// File: doc/BRIEF.md
# Serial Control Register Port

This block is the control-side slave of a converter device. An external controller shifts 16-bit command words into it over a four-wire serial link (serial clock, active-low select, data in, data out). The serial clock has no fixed relation to the system clock or to the audio frame clock. Each word carries a register address, a direction bit, a reserved bit and a 10-bit data field. A write updates one of the device's control registers. A read makes the port return the addressed value on data out during the next transfer.

The serial word is assembled in the serial clock domain. It is then handed to the system clock through a toggle flag and a two-flop synchroniser. The register file, the read-back path and an initialization timer run on the system clock. The upper addresses do not hold storage. They return status values, such as peak levels, that the device supplies, and each read of one of them sends a one-cycle clear pulse back to its source. After reset, the port reports busy until a set number of frame strobes has arrived, and it discards writes during that window.

Top module: `spi_ctl_port`

## Requirements
- R1: A command word is 16 bits, shifted MSB first on rising serial clock edges while the select is low. Bits [15:12] hold the address, bit 11 the direction (1 = read, 0 = write), bit 10 is reserved and ignored, and bits [9:0] hold the data. A completed write to a storage address (0 to RO_BASE-1) sets that register to the data field.
- R2: While reset is high, and after it is released, storage addresses 0 to VOL_REGS-1 (0 to 7) hold 0x3FF, the remaining storage addresses hold 0, and busy_o is 1.
- R3: After reset, busy_o stays 1 until the INIT_FRAMES-th (20th) frame strobe. It is 0 from the next cycle on and does not return to 1 before the next reset.
- R4: A write that completes while busy_o is 1 leaves every register unchanged.
- R5: After a read command, the next transfer returns {address[3:0], 2'b00, value[9:0]} on data out, MSB first, each bit valid before the rising serial clock edge that samples it. Data out is 0 while the select is high.
- R6: Addresses RO_BASE and above (14, 15) are read-only. A read of address RO_BASE+k returns stat_i[k*10 +: 10], and a write to such an address changes nothing.
- R7: A read of address RO_BASE+k raises stat_clr_o[k] for exactly one system clock cycle. No other bit rises, and nothing rises for reads of storage addresses or for writes.
- R8: A transfer in which the select rises before 16 serial clocks is discarded. Serial clocks beyond the 16th within one select window are ignored.
- R9: The registers change only in response to a completed, accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset/power-down; it also clears the serial-side hand-off flag |
| frame_tick_i | input | 1 | One-cycle strobe per audio frame, used to time the initialization window |
| sclk_i | input | 1 | Serial clock from the controller |
| cs_n_i | input | 1 | Active-low select that frames one command word |
| mosi_i | input | 1 | Serial command data in |
| miso_o | output | 1 | Serial read data out |
| busy_o | output | 1 | High during the post-reset initialization window |
| ctl_regs_o | output | RO_BASE*10 | All storage registers, address a at bits [a*10 +: 10] |
| stat_i | input | (16-RO_BASE)*10 | Status values returned for the read-only addresses |
| stat_clr_o | output | 16-RO_BASE | Clear-on-read pulse, one per read-only address |

## Verification
The checker assumes that two completed words are never closer together than the synchroniser latency. It also assumes that a word, once taken, stays stable until the system side has captured it. Both hold when serial clock edges are several system clocks apart and when the select stays high for some system cycles between transfers. The bench runs the serial clock at one eighth of the system rate and waits a dozen system clocks after each transfer. The read-back register is read from the serial side without synchronisation, so the bench never starts a transfer while a command is still in flight. It drives the frame strobe only through its own task, which keeps the count of strobes in the initialization window exact.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 10;
  localparam int REG_COUNT = 2 ** ADDR_W;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              rd;
    logic              rsvd;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/spi_ctl_serial.sv
module spi_ctl_serial
  import spi_ctl_pkg::*;
(
  input  logic              rst_i,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              mosi_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              miso_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              rx_tgl_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-2:0] shreg;
  logic [CNT_W-1:0]  out_idx;

  // bit counter cleared whenever select is high, saturates after a full word
  always_ff @(posedge sclk_i or posedge cs_n_i) begin
    if (cs_n_i) begin
      bit_cnt <= '0;
    end else if (bit_cnt != FULL) begin
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge sclk_i) begin
    if (!cs_n_i && bit_cnt < LAST) begin
      shreg <= {shreg[WORD_W-3:0], mosi_i};
    end
  end

  // word committed on the 16th edge, announced by a toggle
  always_ff @(posedge sclk_i or posedge rst_i) begin
    if (rst_i) begin
      rx_word_o <= '0;
      rx_tgl_o  <= 1'b0;
    end else if (!cs_n_i && bit_cnt == LAST) begin
      rx_word_o <= {shreg, mosi_i};
      rx_tgl_o  <= ~rx_tgl_o;
    end
  end

  assign out_idx = LAST - bit_cnt;
  assign miso_o  = (!cs_n_i && bit_cnt != FULL) ? tx_word_i[out_idx[IDX_W-1:0]] : 1'b0;
endmodule

// File: rtl/spi_ctl_cdc.sv
module spi_ctl_cdc
  import spi_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tgl_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              cmd_valid_o,
  output cmd_t              cmd_o
);
  logic [2:0] sync_q;
  logic       edge_seen;

  assign edge_seen = sync_q[2] ^ sync_q[1];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q      <= '0;
      cmd_valid_o <= 1'b0;
      cmd_o       <= '0;
    end else begin
      sync_q      <= {sync_q[1:0], tgl_i};
      cmd_valid_o <= edge_seen;
      if (edge_seen) begin
        cmd_o <= cmd_t'(word_i);
      end
    end
  end
endmodule

// File: rtl/spi_ctl_init.sv
module spi_ctl_init #(
  parameter int INIT_FRAMES = 20
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic frame_tick_i,
  output logic busy_o
);
  localparam int FC_W = $clog2(INIT_FRAMES + 1);
  localparam logic [FC_W-1:0] LAST_FRAME = FC_W'(INIT_FRAMES - 1);

  logic [FC_W-1:0] frame_cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      frame_cnt <= '0;
      busy_o    <= 1'b1;
    end else if (busy_o && frame_tick_i) begin
      frame_cnt <= frame_cnt + 1'b1;
      if (frame_cnt == LAST_FRAME) begin
        busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_ctl_regfile.sv
module spi_ctl_regfile
  import spi_ctl_pkg::*;
#(
  parameter int RO_BASE  = 14,
  parameter int VOL_REGS = 8,
  localparam int RO_COUNT = REG_COUNT - RO_BASE
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       cmd_valid_i,
  input  cmd_t                       cmd_i,
  input  logic                       busy_i,
  input  logic [RO_COUNT*DATA_W-1:0] stat_i,
  output logic [RO_BASE*DATA_W-1:0]  ctl_regs_o,
  output logic [WORD_W-1:0]          rd_word_o,
  output logic [RO_COUNT-1:0]        stat_clr_o
);
  logic [DATA_W-1:0] regs [RO_BASE];
  logic [DATA_W-1:0] rd_val;

  for (genvar g = 0; g < RO_BASE; g++) begin : g_reg
    localparam logic [DATA_W-1:0] DEF = (g < VOL_REGS) ? {DATA_W{1'b1}} : '0;
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        regs[g] <= DEF;
      end else if (cmd_valid_i && !cmd_i.rd && !busy_i && cmd_i.addr == ADDR_W'(g)) begin
        regs[g] <= cmd_i.data;
      end
    end
    assign ctl_regs_o[g*DATA_W +: DATA_W] = regs[g];
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < RO_BASE; i++) begin
      if (cmd_i.addr == ADDR_W'(i)) rd_val = regs[i];
    end
    for (int k = 0; k < RO_COUNT; k++) begin
      if (cmd_i.addr == ADDR_W'(RO_BASE + k)) rd_val = stat_i[k*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rd_word_o  <= '0;
      stat_clr_o <= '0;
    end else begin
      stat_clr_o <= '0;
      if (cmd_valid_i && cmd_i.rd) begin
        rd_word_o <= {cmd_i.addr, 2'b00, rd_val};
        for (int k = 0; k < RO_COUNT; k++) begin
          if (cmd_i.addr == ADDR_W'(RO_BASE + k)) stat_clr_o[k] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int INIT_FRAMES = 20,
  parameter int RO_BASE     = 14,
  parameter int VOL_REGS    = 8,
  localparam int RO_COUNT   = REG_COUNT - RO_BASE
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       frame_tick_i,
  input  logic                       sclk_i,
  input  logic                       cs_n_i,
  input  logic                       mosi_i,
  output logic                       miso_o,
  output logic                       busy_o,
  output logic [RO_BASE*DATA_W-1:0]  ctl_regs_o,
  input  logic [RO_COUNT*DATA_W-1:0] stat_i,
  output logic [RO_COUNT-1:0]        stat_clr_o
);
  logic [WORD_W-1:0] rx_word;
  logic              rx_tgl;
  logic [WORD_W-1:0] rd_word;
  logic              cmd_valid;
  cmd_t              cmd;

  spi_ctl_serial u_serial (
    .rst_i     (rst_i),
    .sclk_i    (sclk_i),
    .cs_n_i    (cs_n_i),
    .mosi_i    (mosi_i),
    .tx_word_i (rd_word),
    .miso_o    (miso_o),
    .rx_word_o (rx_word),
    .rx_tgl_o  (rx_tgl)
  );

  spi_ctl_cdc u_cdc (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .tgl_i       (rx_tgl),
    .word_i      (rx_word),
    .cmd_valid_o (cmd_valid),
    .cmd_o       (cmd)
  );

  spi_ctl_init #(.INIT_FRAMES(INIT_FRAMES)) u_init (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .frame_tick_i (frame_tick_i),
    .busy_o       (busy_o)
  );

  spi_ctl_regfile #(.RO_BASE(RO_BASE), .VOL_REGS(VOL_REGS)) u_regs (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cmd_valid_i (cmd_valid),
    .cmd_i       (cmd),
    .busy_i      (busy_o),
    .stat_i      (stat_i),
    .ctl_regs_o  (ctl_regs_o),
    .rd_word_o   (rd_word),
    .stat_clr_o  (stat_clr_o)
  );
endmodule

// File: rtl/spi_ctl_port_chk.sv
module spi_ctl_port_chk
  import spi_ctl_pkg::*;
#(
  parameter int RO_BASE  = 14,
  localparam int RO_COUNT = REG_COUNT - RO_BASE
) (
  input logic                      clk_i,
  input logic                      rst_i,
  input logic                      cmd_valid,
  input logic                      busy_o,
  input logic [RO_BASE*DATA_W-1:0] ctl_regs_o,
  input logic [RO_COUNT-1:0]       stat_clr_o
);
  // R4 and R9: registers move only after an accepted write
  a_r9_regs_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (!cmd_valid || busy_o) |=> $stable(ctl_regs_o));

  a_r3_busy_stays_low: assert property (@(posedge clk_i) disable iff (rst_i)
    !busy_o |=> !busy_o);

  a_r7_clr_onehot: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(stat_clr_o));

  a_r7_clr_from_cmd: assert property (@(posedge clk_i) disable iff (rst_i)
    (|stat_clr_o) |-> $past(cmd_valid));

  a_r7_clr_single: assert property (@(posedge clk_i) disable iff (rst_i)
    (|stat_clr_o) |=> (stat_clr_o == '0));

  a_r1_cmd_single: assert property (@(posedge clk_i) disable iff (rst_i)
    cmd_valid |=> !cmd_valid);
endmodule

bind spi_ctl_port spi_ctl_port_chk #(.RO_BASE(RO_BASE)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .cmd_valid  (cmd_valid),
  .busy_o     (busy_o),
  .ctl_regs_o (ctl_regs_o),
  .stat_clr_o (stat_clr_o)
);

// File: tb/spi_ctl_port_tb.sv
module spi_ctl_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SCLK_HALF  = 40;
  localparam int RO_BASE    = 14;
  localparam int DW         = 10;

  typedef struct packed {
    logic [3:0]  addr;
    logic        rsvd;
    logic [9:0]  data;
    logic [3:0]  chk_addr;
    logic [9:0]  chk_exp;
  } vec_t;

  // writes after the init window; R6 row writes a read-only address
  localparam vec_t VECS [6] = '{
    '{4'h2, 1'b0, 10'h1A5, 4'h2, 10'h1A5},
    '{4'h0, 1'b0, 10'h000, 4'h0, 10'h000},
    '{4'hD, 1'b0, 10'h3FF, 4'hD, 10'h3FF},
    '{4'h5, 1'b1, 10'h0F0, 4'h5, 10'h0F0},
    '{4'hE, 1'b0, 10'h123, 4'hD, 10'h3FF},
    '{4'h7, 1'b0, 10'h2AA, 4'h7, 10'h2AA}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_tick = 1'b0;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  logic busy;
  logic [RO_BASE*DW-1:0] ctl_regs;
  logic [2*DW-1:0] stat = '0;
  logic [1:0] stat_clr;

  int n_chk = 0;
  int n_fail = 0;
  int clr_cnt0 = 0;
  int clr_cnt1 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (stat_clr[0]) clr_cnt0++;
    if (stat_clr[1]) clr_cnt1++;
  end

  spi_ctl_port dut_i (
    .clk_i        (clk),
    .rst_i        (rst),
    .frame_tick_i (frame_tick),
    .sclk_i       (sclk),
    .cs_n_i       (cs_n),
    .mosi_i       (mosi),
    .miso_o       (miso),
    .busy_o       (busy),
    .ctl_regs_o   (ctl_regs),
    .stat_i       (stat),
    .stat_clr_o   (stat_clr)
  );

  function automatic logic [15:0] mk(input logic [3:0] a, input logic rd,
                                     input logic rs, input logic [9:0] d);
    return {a, rd, rs, d};
  endfunction

  function automatic logic [9:0] reg_of(input int a);
    return ctl_regs[a*DW +: DW];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // nbits clocks, word left-aligned in bits_w; returns first 16 bits of data out
  task automatic xfer(input logic [31:0] bits_w, input int nbits, output logic [15:0] got);
    got = '0;
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = bits_w[31-i];
      #SCLK_HALF;
      if (i < 16) got[15-i] = miso;
      sclk = 1'b1;
      #SCLK_HALF;
      sclk = 1'b0;
    end
    #SCLK_HALF;
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) frame_tick = 1'b1;
      @(negedge clk) frame_tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] got;
    int c0;
    int c1;
    do_reset();

    // R2: defaults and busy after reset
    check("R2 reg0 default", reg_of(0), 10'h3FF);
    check("R2 reg7 default", reg_of(7), 10'h3FF);
    check("R2 reg8 default", reg_of(8), 10'h000);
    check("R2 busy after reset", busy, 1'b1);
    check("R5 miso idle", miso, 1'b0);

    // R4: write during init window is dropped
    xfer({mk(4'h3, 1'b0, 1'b0, 10'h055), 16'h0}, 16, got);
    check("R4 write while busy", reg_of(3), 10'h3FF);

    // R3: window length in frames
    frames(19);
    check("R3 busy after 19 frames", busy, 1'b1);
    frames(1);
    check("R3 busy cleared at 20th frame", busy, 1'b0);
    frames(3);
    check("R3 busy stays low", busy, 1'b0);

    // R1, R6, R9: table of writes
    for (int v = 0; v < 6; v++) begin
      xfer({mk(VECS[v].addr, 1'b0, VECS[v].rsvd, VECS[v].data), 16'h0}, 16, got);
      check("R1 R6 R9 table write", reg_of(VECS[v].chk_addr), VECS[v].chk_exp);
    end
    check("R9 reg3 untouched", reg_of(3), 10'h3FF);

    // R5: read back of storage registers
    xfer({mk(4'h2, 1'b1, 1'b0, 10'h0), 16'h0}, 16, got);
    xfer({mk(4'hF, 1'b0, 1'b0, 10'h0), 16'h0}, 16, got);
    check("R5 read reg2", got, {4'h2, 2'b00, 10'h1A5});
    xfer({mk(4'h7, 1'b1, 1'b0, 10'h0), 16'h0}, 16, got);
    xfer({mk(4'hF, 1'b0, 1'b0, 10'h0), 16'h0}, 16, got);
    check("R5 read reg7", got, {4'h7, 2'b00, 10'h2AA});

    // R6, R7: read-only status and clear pulse
    stat = {10'h2C7, 10'h155};
    c0 = clr_cnt0;
    c1 = clr_cnt1;
    xfer({mk(4'hE, 1'b1, 1'b0, 10'h0), 16'h0}, 16, got);
    check("R7 clear pulse addr14", clr_cnt0 - c0, 1);
    check("R7 no pulse addr15", clr_cnt1 - c1, 0);
    xfer({mk(4'hF, 1'b0, 1'b0, 10'h0), 16'h0}, 16, got);
    check("R6 read status addr14", got, {4'hE, 2'b00, 10'h155});
    check("R7 no pulse on write", clr_cnt1 - c1, 0);
    c0 = clr_cnt0;
    xfer({mk(4'h5, 1'b1, 1'b0, 10'h0), 16'h0}, 16, got);
    check("R7 no pulse on storage read", clr_cnt0 - c0, 0);

    // R8: short transfer dropped, long transfer truncated
    xfer({mk(4'h3, 1'b0, 1'b0, 10'h0AB), 16'h0}, 8, got);
    check("R8 short transfer dropped", reg_of(3), 10'h3FF);
    xfer({mk(4'h4, 1'b0, 1'b0, 10'h155), 16'hFFFF}, 20, got);
    check("R8 extra clocks ignored", reg_of(4), 10'h155);

    // R2: reset returns defaults
    do_reset();
    check("R2 reg2 back to default", reg_of(2), 10'h3FF);
    check("R2 reg13 back to default", reg_of(13), 10'h000);
    check("R2 busy again", busy, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule